// File: doc/BRIEF.md
# Isochronous Audio Packet Cadence Generator

This block tells an isochronous audio transmitter how much to send in each bus cycle. For every accepted step it gives two values. The first is a data-block count. The second is a presentation-time offset in bus ticks, or the marker `0xFFFF` when the cycle carries no timestamp. One bus cycle is 3072 ticks, and the bus runs 8000 cycles per second.

A single-cycle start pulse loads the sample-rate code and the transfer mode, and it resets all cadence state. The offset follows a running tick counter. Below one cycle, the counter grows by a rate-dependent step. At one cycle or more, it drops by one cycle. For the 44.1 kHz family the step is fractional: an exact phase recurrence adds one extra tick at fixed phases. In non-blocking mode, the 44.1 kHz family also spreads its data blocks with a second phase counter. In blocking mode, a cycle carries either a full timestamp interval of blocks or none.

The consumer pulls pairs through a valid/ready handshake. A pair stays registered and unchanged until the consumer accepts it, and acceptance makes the block produce the next pair.

Top module: `cadence_gen`

## Requirements
- R1: One cycle after a start pulse, `valid_o` is low, even if the block was already running. On the next cycle it is high and shows the first pair of the new stream.
- R2: While `valid_o` is high and `ready_i` is low, `offset_o` and `blocks_o` hold their values and `valid_o` stays high.
- R3: At start the running offset is set to 3072. The first pair after start therefore has offset 0.
- R4: When the updated running offset is 3072 or more, `offset_o` is 0xFFFF. The running offset itself still keeps the true value, and the next step subtracts 3072 from it.
- R5: For rate codes 0, 2, 4 and 6, a running offset below 3072 grows by 3072 at code 0 and by 1024 at the other codes.
- R6: For rate codes 1, 3 and 5, a running offset below 3072 grows by 1386, plus 1 when either of these holds:
  - (p mod 13) is non-zero and a multiple of 4;
  - p equals 146.

  Here p is an offset phase that starts at 67, advances only on such additions, and wraps from 146 to 0.
- R7: In blocking mode (`blocking_i`=1 at start), `blocks_o` is the timestamp interval when the offset is valid, and 0 when the offset is 0xFFFF.
- R8: Rate codes are 0=32 kHz, 1=44.1 kHz, 2=48 kHz, 3=88.2 kHz, 4=96 kHz, 5=176.4 kHz and 6=192 kHz. The timestamp interval is 8 for codes 0 to 2, 16 for codes 3 and 4, and 32 for codes 5 and 6.
- R9: In non-blocking mode, the block count is constant for the non-44.1 rates: 4 at code 0, 6 at code 2, 12 at code 4 and 24 at code 6.
- R10: In non-blocking mode at code 1, the count is 5 + ((q bit 0) XOR (q==0 OR q>=40)). Here q is a block phase that starts at 0, advances once per pair, and wraps from 79 to 0.
- R11: In non-blocking mode at codes 3 and 5, the count is 11*k + (q==0), with k = code>>1. The block phase q wraps at 80>>k, which is 40 for code 3 and 20 for code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle start; loads rate and mode and resets state |
| rate_i | input | 3 | Sample-rate code, sampled at start |
| blocking_i | input | 1 | Transfer mode, sampled at start (1 = blocking) |
| ready_i | input | 1 | Consumer accepts the current pair |
| valid_o | output | 1 | A pair is present |
| blocks_o | output | 6 | Data blocks for this cycle |
| offset_o | output | 16 | Tick offset, or 0xFFFF for no timestamp |

## Verification
The assertions assume that `rate_i` holds one of the seven defined codes whenever `start_i` is high. They also assume that `start_i` is pulsed before any pair is expected. On those assumptions they bound the offset and tie the block count to the mode. The stimulus draws codes only from 0 to 6 and starts every session with a single-cycle pulse. It mixes random `ready_i` stalls with one restart in the middle of a stream. Each accepted pair is compared against a bench model that carries its own running offset and both phase counters.

// File: rtl/cadence_pkg.sv
package cadence_pkg;
  typedef logic [2:0] rate_t;

  localparam rate_t RATE_32K  = 3'd0;
  localparam rate_t RATE_44K1 = 3'd1;
  localparam rate_t RATE_48K  = 3'd2;
  localparam rate_t RATE_96K  = 3'd4;
  localparam rate_t RATE_192K = 3'd6;

  function automatic logic is_frac(input rate_t r);
    return (r == 3'd1) || (r == 3'd3) || (r == 3'd5);
  endfunction

  // events per timestamp interval
  function automatic logic [5:0] ts_interval(input rate_t r);
    if (r <= 3'd2)      return 6'd8;
    else if (r <= 3'd4) return 6'd16;
    else                return 6'd32;
  endfunction

  function automatic logic [5:0] fixed_blocks(input rate_t r);
    case (r)
      RATE_32K:  return 6'd4;
      RATE_96K:  return 6'd12;
      RATE_192K: return 6'd24;
      default:   return 6'd6;
    endcase
  endfunction
endpackage

// File: rtl/cadence_offset.sv
module cadence_offset
  import cadence_pkg::*;
#(
  parameter int CYCLE_TICKS = 3072,
  parameter int FRAC_BASE   = 1386,
  parameter int PH_WRAP     = 147,
  parameter int PH_INIT     = 67,
  parameter int PH_MOD      = 13,
  parameter int OFF_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             adv_i,
  input  rate_t            rate_i,
  output logic [OFF_W-1:0] off_o,
  output logic             no_info_o
);
  localparam int LW = $clog2(2 * CYCLE_TICKS);
  localparam int PW = $clog2(PH_WRAP);
  localparam logic [LW-1:0] CYC   = LW'(CYCLE_TICKS);
  localparam logic [LW-1:0] THIRD = LW'(CYCLE_TICKS / 3);
  localparam logic [LW-1:0] BASE  = LW'(FRAC_BASE);
  localparam logic [PW-1:0] PLAST = PW'(PH_WRAP - 1);

  logic [LW-1:0] last_q, last_d, step;
  logic [PW-1:0] ph_q, ph_d, idx;
  logic          bump;

  always_comb begin
    idx  = ph_q % PW'(PH_MOD);
    bump = ((idx != '0) && (idx[1:0] == 2'b00)) || (ph_q == PLAST);
    if (is_frac(rate_i))          step = BASE + LW'(bump);
    else if (rate_i == RATE_32K)  step = CYC;
    else                          step = THIRD;
    ph_d = ph_q;
    if (last_q < CYC) begin
      last_d = last_q + step;
      if (is_frac(rate_i)) ph_d = (ph_q == PLAST) ? '0 : ph_q + 1'b1;
    end else begin
      last_d = last_q - CYC;
    end
    no_info_o = (last_d >= CYC);
    off_o     = no_info_o ? {OFF_W{1'b1}} : OFF_W'(last_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= CYC;
      ph_q   <= PW'(PH_INIT);
    end else if (start_i) begin
      last_q <= CYC;
      ph_q   <= PW'(PH_INIT);
    end else if (adv_i) begin
      last_q <= last_d;
      ph_q   <= ph_d;
    end
  end
endmodule

// File: rtl/cadence_blocks.sv
module cadence_blocks
  import cadence_pkg::*;
#(
  parameter int PH_WRAP = 80,
  parameter int BLK_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             adv_i,
  input  rate_t            rate_i,
  input  logic             blocking_i,
  input  logic             no_info_i,
  output logic [BLK_W-1:0] blocks_o
);
  localparam int PW   = $clog2(PH_WRAP);
  localparam int HALF = PH_WRAP / 2;

  logic [PW-1:0] ph_q, ph_d, wrap;
  logic [1:0]    k;
  logic          odd, tail;

  always_comb begin
    k    = rate_i[2:1];
    wrap = PW'(PH_WRAP >> k);
    odd  = ph_q[0];
    tail = (ph_q == '0) || (ph_q >= PW'(HALF));
    ph_d = ph_q;
    if (blocking_i) begin
      blocks_o = no_info_i ? '0 : BLK_W'(ts_interval(rate_i));
    end else if (!is_frac(rate_i)) begin
      blocks_o = BLK_W'(fixed_blocks(rate_i));
    end else begin
      if (rate_i == RATE_44K1) blocks_o = BLK_W'(5) + BLK_W'(odd ^ tail);
      else                     blocks_o = BLK_W'(11) * BLK_W'(k) + BLK_W'(ph_q == '0);
      ph_d = (ph_q + 1'b1 >= wrap) ? '0 : ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ph_q <= '0;
    else if (start_i)  ph_q <= '0;
    else if (adv_i)    ph_q <= ph_d;
  end
endmodule

// File: rtl/cadence_gen.sv
module cadence_gen
  import cadence_pkg::*;
#(
  parameter int CYCLE_TICKS  = 3072,
  parameter int FRAC_BASE    = 1386,
  parameter int OFF_PH_WRAP  = 147,
  parameter int OFF_PH_INIT  = 67,
  parameter int BLK_PH_WRAP  = 80,
  parameter int OFF_W        = 16,
  parameter int BLK_W        = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       rate_i,
  input  logic             blocking_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [BLK_W-1:0] blocks_o,
  output logic [OFF_W-1:0] offset_o
);
  rate_t            rate_q;
  logic             blocking_q, run_q, valid_q, adv;
  logic [OFF_W-1:0] off_nxt, off_q;
  logic [BLK_W-1:0] blk_nxt, blk_q;
  logic             no_info;

  assign adv = run_q && !start_i && (!valid_q || ready_i);

  cadence_offset #(
    .CYCLE_TICKS(CYCLE_TICKS), .FRAC_BASE(FRAC_BASE), .PH_WRAP(OFF_PH_WRAP),
    .PH_INIT(OFF_PH_INIT), .PH_MOD(13), .OFF_W(OFF_W)
  ) u_off (
    .clk_i, .rst_ni, .start_i, .adv_i(adv), .rate_i(rate_q),
    .off_o(off_nxt), .no_info_o(no_info)
  );

  cadence_blocks #(.PH_WRAP(BLK_PH_WRAP), .BLK_W(BLK_W)) u_blk (
    .clk_i, .rst_ni, .start_i, .adv_i(adv), .rate_i(rate_q),
    .blocking_i(blocking_q), .no_info_i(no_info), .blocks_o(blk_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0; blocking_q <= 1'b0; run_q <= 1'b0; valid_q <= 1'b0;
      off_q <= '0;  blk_q <= '0;
    end else if (start_i) begin
      rate_q <= rate_i; blocking_q <= blocking_i; run_q <= 1'b1; valid_q <= 1'b0;
    end else if (adv) begin
      valid_q <= 1'b1; off_q <= off_nxt; blk_q <= blk_nxt;
    end
  end

  assign valid_o  = valid_q;
  assign blocks_o = blk_q;
  assign offset_o = off_q;
endmodule

// File: rtl/cadence_gen_chk.sv
module cadence_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        ready_i,
  input logic        valid_o,
  input logic [5:0]  blocks_o,
  input logic [15:0] offset_o,
  input logic        blocking_q
);
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o); // R1
  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !start_i) |=> (valid_o && $stable(offset_o) && $stable(blocks_o))); // R2
  AST_OFFSET_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && offset_o != 16'hFFFF) |-> offset_o < 16'd3072); // R4
  AST_BLOCKING_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && blocking_q && offset_o == 16'hFFFF) |-> blocks_o == 6'd0); // R7
  AST_BLOCKING_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && blocking_q && offset_o != 16'hFFFF) |->
      (blocks_o == 6'd8 || blocks_o == 6'd16 || blocks_o == 6'd32)); // R8
  AST_NONBLOCK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !blocking_q) |-> (blocks_o >= 6'd4 && blocks_o <= 6'd24)); // R9
endmodule

bind cadence_gen cadence_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_i(ready_i),
  .valid_o(valid_o), .blocks_o(blocks_o), .offset_o(offset_o),
  .blocking_q(blocking_q)
);

// File: tb/cadence_gen_tb.sv
module cadence_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  rate_i = '0;
  logic        blocking_i = 1'b0;
  logic        ready_i = 1'b0;
  logic        valid_o;
  logic [5:0]  blocks_o;
  logic [15:0] offset_o;

  int total = 0, bad = 0;
  int m_last, m_oph, m_dph, m_rate;
  bit m_blk;

  always #5 clk_i = ~clk_i;

  cadence_gen u_dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_next(output int eo, output int eb);
    int step, i, iv;
    if (m_last < 3072) begin
      if (m_rate == 1 || m_rate == 3 || m_rate == 5) begin
        i = m_oph % 13;
        step = 1386 + ((((i != 0) && (i % 4 == 0)) || m_oph == 146) ? 1 : 0);
        m_oph = (m_oph + 1) % 147;
      end else step = (m_rate == 0) ? 3072 : 1024;
      m_last += step;
    end else m_last -= 3072;
    eo = (m_last >= 3072) ? 'hFFFF : m_last;
    iv = (m_rate <= 2) ? 8 : (m_rate <= 4) ? 16 : 32;
    if (m_blk) eb = (eo == 'hFFFF) ? 0 : iv;
    else case (m_rate)
      0: eb = 4;
      2: eb = 6;
      4: eb = 12;
      6: eb = 24;
      1: begin
        eb = 5 + ((m_dph & 1) ^ ((m_dph == 0 || m_dph >= 40) ? 1 : 0));
        m_dph = (m_dph + 1) % 80;
      end
      3: begin eb = 11 + (m_dph == 0 ? 1 : 0); m_dph = (m_dph + 1) % 40; end
      default: begin eb = 22 + (m_dph == 0 ? 1 : 0); m_dph = (m_dph + 1) % 20; end
    endcase
  endtask

  task automatic do_start(input int r, input bit b);
    @(negedge clk_i);
    ready_i = 1'b0; start_i = 1'b1; rate_i = 3'(r); blocking_i = b;
    m_rate = r; m_blk = b; m_last = 3072; m_oph = 67; m_dph = 0;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R1 valid low after start", int'(valid_o), 0);
  endtask

  task automatic run(input int n, input bit first_chk);
    int eo, eb, po, pb;
    bit pstall = 0, first = first_chk;
    for (int c = 0; c < n; c++) begin
      @(negedge clk_i);
      if (pstall) begin
        check("R2 valid held", int'(valid_o), 1);
        check("R2 offset held", int'(offset_o), po);
        check("R2 blocks held", int'(blocks_o), pb);
      end
      ready_i = ($urandom % 4) != 0;
      pstall = valid_o && !ready_i;
      po = offset_o; pb = blocks_o;
      if (valid_o && ready_i) begin
        model_next(eo, eb);
        if (first) begin
          check("R3 first offset", int'(offset_o), 0);
          first = 0;
        end
        if (eo == 'hFFFF) check("R4 no-info marker", int'(offset_o), eo);
        else if (m_rate == 1 || m_rate == 3 || m_rate == 5)
          check("R6 fractional offset", int'(offset_o), eo);
        else check("R5 integral offset", int'(offset_o), eo);
        if (m_blk) check("R7 R8 blocking count", int'(blocks_o), eb);
        else if (m_rate == 1) check("R10 count", int'(blocks_o), eb);
        else if (m_rate == 3 || m_rate == 5) check("R11 count", int'(blocks_o), eb);
        else check("R9 count", int'(blocks_o), eb);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check("R1 reset valid", int'(valid_o), 0);
    rst_ni = 1'b1;
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 7; r++) begin
        do_start(r, b[0]);
        @(negedge clk_i);
        check("R1 first pair valid", int'(valid_o), 1);
        run(500, 1'b1);
      end
    // restart mid-stream
    do_start(1, 1'b0);
    run(40, 1'b1);
    do_start(3, 1'b0);
    run(200, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule